// File: doc/BRIEF.md
# Class-D Protection Fault Latch

This block holds the protection state of a four-output switching power stage. It takes raw comparator flags for per-output over-current, junction thermal warning, junction thermal error and supply under-voltage. It also takes two active-low pair resets, one for outputs 1/2 and one for outputs 3/4. From these it decides which outputs must be forced to high impedance. It also drives the pull-down enables of four active-low open-drain status pins.

The scope of a shutdown depends on the fault. An over-current stops only the pair that contains the offending output. A thermal error or an under-voltage stops every output. A thermal warning is reported and stops nothing. A latched fault is released only when two things hold: its condition has gone away, and the reset or resets that govern it have risen after that. The under-voltage comparator arrives as two separate inputs, one for the assert threshold and one for the release threshold, so the hysteresis is kept.

Top module: `cld_fault_latch`

## Requirements
- R1: Every comparator input and both pair resets pass through a two-flop synchronizer. A change held steady on a raw input is seen at the outputs within four clock edges.
- R2: An over-current on output 1 or 2 latches pair 0. That sets oc_pd_o[0] and forces hiz_o[1:0] high and leaves hiz_o[3:2] alone. An over-current on output 3 or 4 does the same for pair 1, using oc_pd_o[1] and hiz_o[3:2].
- R3: A latched over-current clears only on a low-to-high edge of its pair reset, and only when both outputs of the pair are below the limit. An edge that comes while the condition is still present leaves the latch set, so a later edge is needed.
- R4: A thermal error sets err_pd_o and forces all four hiz_o bits high.
- R5: A thermal or under-voltage latch clears only after both pair resets have risen once the condition is gone. A rise on only one pair reset keeps it set.
- R6: tw_pd_o follows the synchronized thermal-warning input and is not latched. A warning alone forces no output to high impedance.
- R7: The under-voltage condition sets while uv_assert_raw_i is high. It stays set until uv_release_raw_i goes high while uv_assert_raw_i is low, and only then can recovery proceed.
- R8: The pin levels (warning pin, error pin) are the inverse of (tw_pd_o, err_pd_o). They read 11 in normal operation, 01 for a warning only, 10 for a thermal error or under-voltage without a warning, and 00 for a warning together with an error.
- R9: While a pair reset is low, both outputs of that pair are high impedance. The status flags do not change.
- R10: While rst_ni is low, every pull-down enable is 0 and every hiz_o bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| oc_raw_i | input | 4 | Per-output over-current comparator, asynchronous |
| tw_raw_i | input | 1 | Thermal-warning comparator, asynchronous |
| te_raw_i | input | 1 | Thermal-error comparator, asynchronous |
| uv_assert_raw_i | input | 1 | Supply below the falling threshold, asynchronous |
| uv_release_raw_i | input | 1 | Supply above the rising threshold, asynchronous |
| pair_rst_n_i | input | 2 | Active-low pair resets, bit 0 for outputs 1/2 and bit 1 for outputs 3/4 |
| hiz_o | output | 4 | Force-high-impedance request per output |
| tw_pd_o | output | 1 | Pull-down enable of the thermal-warning pin |
| err_pd_o | output | 1 | Pull-down enable of the thermal/under-voltage error pin |
| oc_pd_o | output | 2 | Pull-down enable of the over-current pin of each pair |

## Verification
Four properties are checked on every cycle:
- An over-current flag always comes with high impedance on its pair.
- The error flag always comes with all outputs off.
- A low pair reset always turns its pair off.
- A latch falls only after a reset edge with the condition absent.

Some behaviour only the directed scenarios can show:
- The ordering rules: a reset edge during an active fault must not clear it, one pair reset must not clear a global fault, and the under-voltage hysteresis must hold.
- The cycle latency through the synchronizers.
- The full flag encoding table.

// File: rtl/cld_fault_pkg.sv
package cld_fault_pkg;
  localparam int DEF_PAIRS         = 2;
  localparam int DEF_OUTS_PER_PAIR = 2;
  localparam int SYNC_STAGES       = 2;
endpackage

// File: rtl/cld_sync.sv
module cld_sync import cld_fault_pkg::*; #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [SYNC_STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[SYNC_STAGES-1];
endmodule

// File: rtl/cld_pair_latch.sv
module cld_pair_latch #(
  parameter int OUTS = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OUTS-1:0] oc_i,
  input  logic            rise_i,
  output logic            latched_o
);
  logic cond;
  assign cond = |oc_i;

  // set has priority; release needs a reset edge with the pair clean
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         latched_o <= 1'b0;
    else if (cond)                       latched_o <= 1'b1;
    else if (latched_o && rise_i)        latched_o <= 1'b0;
  end
endmodule

// File: rtl/cld_global_latch.sv
module cld_global_latch #(
  parameter int NUM_PAIRS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cond_i,
  input  logic [NUM_PAIRS-1:0] rise_i,
  output logic                 latched_o
);
  logic [NUM_PAIRS-1:0] seen_q, seen_nxt;
  assign seen_nxt = seen_q | rise_i;

  // each pair's reset edge is remembered only while the condition is absent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latched_o <= 1'b0;
      seen_q    <= '0;
    end else if (cond_i) begin
      latched_o <= 1'b1;
      seen_q    <= '0;
    end else if (latched_o) begin
      if (&seen_nxt) begin
        latched_o <= 1'b0;
        seen_q    <= '0;
      end else begin
        seen_q    <= seen_nxt;
      end
    end else begin
      seen_q <= '0;
    end
  end
endmodule

// File: rtl/cld_fault_latch.sv
module cld_fault_latch import cld_fault_pkg::*; #(
  parameter  int NUM_PAIRS     = DEF_PAIRS,
  parameter  int OUTS_PER_PAIR = DEF_OUTS_PER_PAIR,
  localparam int NUM_OUT       = NUM_PAIRS * OUTS_PER_PAIR
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_OUT-1:0]   oc_raw_i,
  input  logic                 tw_raw_i,
  input  logic                 te_raw_i,
  input  logic                 uv_assert_raw_i,
  input  logic                 uv_release_raw_i,
  input  logic [NUM_PAIRS-1:0] pair_rst_n_i,
  output logic [NUM_OUT-1:0]   hiz_o,
  output logic                 tw_pd_o,
  output logic                 err_pd_o,
  output logic [NUM_PAIRS-1:0] oc_pd_o
);
  localparam int SW = NUM_OUT + NUM_PAIRS + 4;

  logic [SW-1:0]        raw_all, syn_all;
  logic [NUM_OUT-1:0]   oc_s;
  logic                 tw_s, te_s, uv_a_s, uv_r_s;
  logic [NUM_PAIRS-1:0] pair_rst_s, pair_rst_q, pair_rise;
  logic                 uv_cond, gflt;
  logic [NUM_PAIRS-1:0] ocl;

  assign raw_all = {pair_rst_n_i, uv_release_raw_i, uv_assert_raw_i,
                    te_raw_i, tw_raw_i, oc_raw_i};

  cld_sync #(.W(SW)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_all),
    .q_o    (syn_all)
  );

  assign {pair_rst_s, uv_r_s, uv_a_s, te_s, tw_s, oc_s} = syn_all;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pair_rst_q <= '0;
    else         pair_rst_q <= pair_rst_s;
  end
  assign pair_rise = pair_rst_s & ~pair_rst_q;

  // hysteretic supply state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      uv_cond <= 1'b0;
    else if (uv_a_s)  uv_cond <= 1'b1;
    else if (uv_r_s)  uv_cond <= 1'b0;
  end

  cld_global_latch #(.NUM_PAIRS(NUM_PAIRS)) i_glob (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cond_i    (te_s | uv_cond),
    .rise_i    (pair_rise),
    .latched_o (gflt)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    cld_pair_latch #(.OUTS(OUTS_PER_PAIR)) i_pair (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .oc_i      (oc_s[p*OUTS_PER_PAIR +: OUTS_PER_PAIR]),
      .rise_i    (pair_rise[p]),
      .latched_o (ocl[p])
    );
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    assign hiz_o[o] = gflt | ocl[o/OUTS_PER_PAIR] | ~pair_rst_s[o/OUTS_PER_PAIR];
  end

  assign tw_pd_o  = tw_s;
  assign err_pd_o = gflt;
  assign oc_pd_o  = ocl;
endmodule

// File: rtl/cld_fault_latch_chk.sv
module cld_fault_latch_chk #(
  parameter int NUM_PAIRS     = 2,
  parameter int OUTS_PER_PAIR = 2
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic [NUM_PAIRS*OUTS_PER_PAIR-1:0] hiz_o,
  input logic                               tw_pd_o,
  input logic                               err_pd_o,
  input logic [NUM_PAIRS-1:0]               oc_pd_o,
  input logic [NUM_PAIRS-1:0]               pair_rst_s,
  input logic [NUM_PAIRS-1:0]               pair_rise,
  input logic                               te_s,
  input logic                               uv_cond
);
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_p
    AST_OC_PAIR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oc_pd_o[p] |-> &hiz_o[p*OUTS_PER_PAIR +: OUTS_PER_PAIR]); // R2
    AST_OC_RELEASE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(oc_pd_o[p]) |-> $past(pair_rise[p])); // R3
    AST_PAIR_RST_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pair_rst_s[p] |-> &hiz_o[p*OUTS_PER_PAIR +: OUTS_PER_PAIR]); // R9
  end

  AST_ERR_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pd_o |-> &hiz_o); // R4
  AST_TE_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    te_s |=> err_pd_o); // R4
  AST_UV_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_cond |=> err_pd_o); // R7
  AST_ERR_RELEASE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_pd_o) |-> $past(!te_s && !uv_cond && (pair_rise != '0))); // R5
  AST_WARN_NO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tw_pd_o && !err_pd_o && oc_pd_o == '0 && &pair_rst_s) |-> hiz_o == '0); // R6
endmodule

bind cld_fault_latch cld_fault_latch_chk #(
  .NUM_PAIRS(NUM_PAIRS),
  .OUTS_PER_PAIR(OUTS_PER_PAIR)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hiz_o      (hiz_o),
  .tw_pd_o    (tw_pd_o),
  .err_pd_o   (err_pd_o),
  .oc_pd_o    (oc_pd_o),
  .pair_rst_s (pair_rst_s),
  .pair_rise  (pair_rise),
  .te_s       (te_s),
  .uv_cond    (uv_cond)
);

// File: tb/test_cld_fault_latch.sv
`timescale 1ns/1ps
module test_cld_fault_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] oc_raw = '0;
  logic       tw_raw = 1'b0, te_raw = 1'b0, uva_raw = 1'b0, uvr_raw = 1'b0;
  logic [1:0] prst_n = 2'b00;
  logic [3:0] hiz;
  logic       tw_pd, err_pd;
  logic [1:0] oc_pd;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  cld_fault_latch i_cld_fault_latch (
    .clk_i(clk), .rst_ni(rst_n), .oc_raw_i(oc_raw), .tw_raw_i(tw_raw),
    .te_raw_i(te_raw), .uv_assert_raw_i(uva_raw), .uv_release_raw_i(uvr_raw),
    .pair_rst_n_i(prst_n), .hiz_o(hiz), .tw_pd_o(tw_pd), .err_pd_o(err_pd),
    .oc_pd_o(oc_pd)
  );

  // status word {hiz[3:0], tw_pd, err_pd, oc_pd[1:0]}
  task automatic chk(input string tag, input logic [7:0] exp);
    logic [7:0] act;
    act = {hiz, tw_pd, err_pd, oc_pd};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_rst(input logic [1:0] m);
    @(negedge clk); prst_n = prst_n & ~m; settle();
    prst_n = prst_n | m; settle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; prst_n = 2'b11;
    repeat (3) @(negedge clk);
    chk("R10 in reset", 8'b1111_0_0_00);
    rst_n = 1'b1; settle();
    chk("R1 R10 release to normal", 8'b0000_0_0_00);
  endtask

  task automatic t_oc();
    oc_raw = 4'b0010;
    @(negedge clk); @(negedge clk);
    chk("R1 not yet through synchronizer", 8'b0000_0_0_00);
    settle();
    chk("R2 pair0 latched", 8'b0011_0_0_01);
    pulse_rst(2'b01);
    chk("R3 edge while present", 8'b0011_0_0_01);
    oc_raw = '0; settle();
    chk("R3 cleared cond still latched", 8'b0011_0_0_01);
    pulse_rst(2'b01);
    chk("R3 released by edge", 8'b0000_0_0_00);
    oc_raw = 4'b1000; settle(); oc_raw = '0; settle();
    chk("R2 pair1 latched only", 8'b1100_0_0_10);
    pulse_rst(2'b01);
    chk("R3 other pair edge ignored", 8'b1100_0_0_10);
    pulse_rst(2'b10);
    chk("R3 pair1 released", 8'b0000_0_0_00);
  endtask

  task automatic t_thermal();
    te_raw = 1'b1; settle();
    chk("R4 thermal error all off", 8'b1111_0_1_00);
    te_raw = 1'b0; settle();
    chk("R4 stays latched", 8'b1111_0_1_00);
    pulse_rst(2'b01);
    chk("R5 single pair edge", 8'b1111_0_1_00);
    pulse_rst(2'b10);
    chk("R5 both edges release", 8'b0000_0_0_00);
  endtask

  task automatic t_uv();
    uva_raw = 1'b1; settle();
    chk("R7 uv assert", 8'b1111_0_1_00);
    uva_raw = 1'b0; settle();
    pulse_rst(2'b11);
    chk("R7 hysteresis holds", 8'b1111_0_1_00);
    uvr_raw = 1'b1; settle();
    chk("R7 release alone no recovery", 8'b1111_0_1_00);
    pulse_rst(2'b11);
    chk("R5 R7 recovered", 8'b0000_0_0_00);
    uvr_raw = 1'b0; settle();
  endtask

  task automatic t_warn();
    tw_raw = 1'b1; settle();
    chk("R6 warning no shutdown", 8'b0000_1_0_00);
    chk("R8 pins 01", {4'b0000, ~2'b01, 2'b00});
    te_raw = 1'b1; settle();
    chk("R8 pins 00", {4'b1111, ~2'b00, 2'b00});
    te_raw = 1'b0; tw_raw = 1'b0; settle();
    pulse_rst(2'b11);
    chk("R6 warning not latched", 8'b0000_0_0_00);
    uva_raw = 1'b1; settle(); uva_raw = 1'b0;
    chk("R8 pins 10", {4'b1111, ~2'b10, 2'b00});
    uvr_raw = 1'b1; settle(); pulse_rst(2'b11); uvr_raw = 1'b0; settle();
    chk("R8 pins 11", {4'b0000, ~2'b11, 2'b00});
  endtask

  task automatic t_rst_low();
    @(negedge clk); prst_n = 2'b01; settle();
    chk("R9 pair1 held off", 8'b1100_0_0_00);
    prst_n = 2'b11; settle();
    chk("R9 pair1 back", 8'b0000_0_0_00);
  endtask

  initial begin
    t_reset();
    t_oc();
    t_thermal();
    t_uv();
    t_warn();
    t_rst_low();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule